// File: doc/BRIEF.md
# Read-Response Beat Packer

This block turns the beats of one stored frame into read-response beats for a memory-read consumer. Each accepted input beat carries 32 bytes of data, a count of the valid bytes in that beat, and an end-of-frame marker. The block emits the same beat with its byte order reversed. It also emits a byte-enable mask whose bits are reversed to match, so that the valid bytes of a short beat are flagged in the high lanes where the reversal puts them. Each output beat carries a marker for the start of the frame and a marker for its end.

A short beat is legal only at the end of a frame. A short beat anywhere else still passes through, but its error flag is raised. The block has one register stage with a valid/ready handshake on each side. Beats leave in the order they arrived, one cycle after acceptance, and an output beat is held unchanged while the consumer stalls.

Top module: `dma_resp_packer`

## Requirements
- R1: While reset is held, `m_valid` is 0 and `s_ready` is 1. The first beat accepted after reset is treated as the start of a frame.
- R2: Output byte k (bits 8k+7..8k) equals input byte 31-k of the same beat.
- R3: `s_cnt` gives the number of valid bytes modulo 32, where 0 means all 32 bytes are valid. For a count of n between 1 and 31, `m_be` has exactly its top n bits set (bits 31 down to 32-n). For a count of 0, `m_be` is all ones.
- R4: `m_first` is 1 on the first beat accepted after reset and on the first beat accepted after a beat with `s_last`=1. It is 0 on every other beat.
- R5: `m_last` equals the `s_last` of the same beat. A frame of a single beat therefore has both `m_first` and `m_last` set.
- R6: `m_err` is 1 exactly when `s_cnt` is non-zero and `s_last` is 0. A short final beat never raises `m_err`.
- R7: While `m_valid` is 1 and `m_ready` is 0, every output holds its value and `s_ready` is 0.
- R8: Every accepted beat appears at the output exactly once, in acceptance order. A beat accepted at one clock edge is valid at the output after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with s_valid |
| s_data | input | 256 | Input beat data, byte 0 in bits 7..0 |
| s_cnt | input | 5 | Valid byte count modulo 32 (0 = full beat) |
| s_last | input | 1 | Final beat of the frame |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Consumer ready |
| m_data | output | 256 | Byte-reversed beat data |
| m_be | output | 32 | Bit-reversed byte-enable mask |
| m_first | output | 1 | First beat of the frame |
| m_last | output | 1 | Final beat of the frame |
| m_err | output | 1 | Short beat that is not the final beat |

## Verification
The stimulus opens with directed frames: one-beat frames with counts 0, 1 and 31, a two-beat frame with a short middle beat, and a short final beat. These cases separate the all-ones mask from the top-lanes mask and a legal short tail from an illegal one. Several hundred random frames follow. They vary in length, carry random data bytes that expose any lane swap, and occasionally contain a short middle beat. Random valid gaps on the input and random stalls on the output test whether a beat is dropped, duplicated or reordered, and whether the held output stays stable while the consumer waits.

// File: rtl/dma_resp_packer.sv
module dma_resp_packer #(
  parameter int BYTES = 32,
  localparam int DW = BYTES * 8,
  localparam int CW = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  input  logic [CW-1:0]    s_cnt,
  input  logic             s_last,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic [BYTES-1:0] m_be,
  output logic             m_first,
  output logic             m_last,
  output logic             m_err
);

  localparam logic [BYTES-1:0] ONE = BYTES'(1);

  logic             mid;
  logic [DW-1:0]    swapped;
  logic [BYTES-1:0] keep_lo, keep_rev;

  assign s_ready = !m_valid || m_ready;
  assign keep_lo = (s_cnt == '0) ? '1 : ((ONE << s_cnt) - ONE);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign swapped[g*8 +: 8] = s_data[(BYTES-1-g)*8 +: 8];
    assign keep_rev[g]       = keep_lo[BYTES-1-g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      mid     <= 1'b0;
      m_data  <= '0;
      m_be    <= '0;
      m_first <= 1'b0;
      m_last  <= 1'b0;
      m_err   <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) begin
        mid     <= !s_last;
        m_data  <= swapped;
        m_be    <= keep_rev;
        m_first <= !mid;
        m_last  <= s_last;
        m_err   <= (s_cnt != '0) && !s_last;
      end
    end
  end

  assert_be_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_be != '0) && (m_be == ~({BYTES{1'b1}} >> $countones(m_be))));

  assert_err_not_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_err) |-> (!m_last && m_be != '1));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_be) &&
                               $stable(m_first) && $stable(m_last) && $stable(m_err)));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

endmodule

// File: tb/sim_dma_resp_packer.sv
module sim_dma_resp_packer;
  localparam int CLK_PERIOD = 10;
  localparam int BYTES = 32;
  localparam int DW = BYTES * 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, s_valid, s_ready, s_last, m_valid, m_ready, m_first, m_last, m_err;
  logic [DW-1:0] s_data, m_data;
  logic [4:0] s_cnt;
  logic [BYTES-1:0] m_be;

  dma_resp_packer u0 (.clk, .rst_n, .s_valid, .s_ready, .s_data, .s_cnt, .s_last,
                      .m_valid, .m_ready, .m_data, .m_be, .m_first, .m_last, .m_err);

  logic [DW-1:0] q_data[$], e_data[$];
  logic [4:0] q_cnt[$];
  logic q_last[$], e_first[$], e_last[$], e_err[$];
  logic [BYTES-1:0] e_be[$];
  int total = 0, bad = 0;
  bit next_first = 1;

  function automatic logic [DW-1:0] f_swap(logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int i = 0; i < BYTES; i++) r[i*8 +: 8] = d[(BYTES-1-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [BYTES-1:0] f_be(logic [4:0] c);
    logic [BYTES-1:0] r = '0;
    int n = (c == 0) ? BYTES : int'(c);
    for (int i = 0; i < n; i++) r[BYTES-1-i] = 1'b1;
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_beat(logic [DW-1:0] d, logic [4:0] c, logic l);
    q_data.push_back(d); q_cnt.push_back(c); q_last.push_back(l);
    e_data.push_back(f_swap(d)); e_be.push_back(f_be(c));
    e_first.push_back(next_first); e_last.push_back(l);
    e_err.push_back(c != 0 && !l);
    next_first = l;
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] d;
    for (int i = 0; i < DW/32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  logic [DW-1:0] h_data;
  logic [BYTES-1:0] h_be;
  logic h_first, h_last, h_err;
  bit stalled = 0, accepted = 0;
  int stall_phase;

  initial begin
    void'($urandom(32'd4321));
    // directed corner frames
    add_beat(rnd_data(), 5'd0, 1'b1);
    add_beat(rnd_data(), 5'd1, 1'b1);
    add_beat(rnd_data(), 5'd31, 1'b1);
    add_beat(rnd_data(), 5'd7, 1'b0);
    add_beat(rnd_data(), 5'd0, 1'b1);
    add_beat(rnd_data(), 5'd0, 1'b0);
    add_beat(rnd_data(), 5'd12, 1'b1);
    for (int f = 0; f < 400; f++) begin
      int len = 1 + int'($urandom % 5);
      for (int b = 0; b < len; b++) begin
        logic [4:0] c = 5'(($urandom % 6 == 0) ? $urandom : 0);
        if (b == len - 1) c = 5'($urandom);
        add_beat(rnd_data(), c, b == len - 1);
      end
    end

    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; s_cnt = '0; s_last = 1'b0; m_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(m_valid == 1'b0, "R1 m_valid in reset", DW'(m_valid), '0);
    chk(s_ready == 1'b1, "R1 s_ready in reset", DW'(s_ready), DW'(1));
    @(negedge clk);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (accepted) begin
        void'(q_data.pop_front()); void'(q_cnt.pop_front()); void'(q_last.pop_front());
      end
      if (s_valid && !accepted) begin
        // hold pending beat
      end else if (q_data.size() > 0 && ($urandom % 4 != 0)) begin
        s_valid = 1'b1; s_data = q_data[0]; s_cnt = q_cnt[0]; s_last = q_last[0];
      end else begin
        s_valid = 1'b0;
      end
      stall_phase = (cyc / 300) % 3;
      m_ready = (stall_phase == 1) ? ($urandom % 5 == 0) : ($urandom % 4 != 0);
      #1;
      if (stalled) begin
        chk(m_valid == 1'b1, "R7 valid held", DW'(m_valid), DW'(1));
        chk(m_data == h_data && m_be == h_be && m_first == h_first &&
            m_last == h_last && m_err == h_err, "R7 outputs held", m_data, h_data);
      end
      if (m_valid && !m_ready) begin
        chk(s_ready == 1'b0, "R7 s_ready low under stall", DW'(s_ready), '0);
        stalled = 1; h_data = m_data; h_be = m_be; h_first = m_first; h_last = m_last; h_err = m_err;
      end else stalled = 0;
      if (m_valid && m_ready) begin
        if (e_data.size() == 0) chk(1'b0, "R8 extra output beat", m_data, '0);
        else begin
          chk(m_data == e_data[0], "R2 R8 data", m_data, e_data[0]);
          chk(m_be == e_be[0], "R3 byte enable", DW'(m_be), DW'(e_be[0]));
          chk(m_first == e_first[0], "R4 R1 first flag", DW'(m_first), DW'(e_first[0]));
          chk(m_last == e_last[0], "R5 last flag", DW'(m_last), DW'(e_last[0]));
          chk(m_err == e_err[0], "R6 error flag", DW'(m_err), DW'(e_err[0]));
          void'(e_data.pop_front()); void'(e_be.pop_front()); void'(e_first.pop_front());
          void'(e_last.pop_front()); void'(e_err.pop_front());
        end
      end
      accepted = s_valid && s_ready;
      if (e_data.size() == 0 && q_data.size() == (accepted ? 1 : 0) && !m_valid) break;
    end
    chk(e_data.size() == 0, "R8 all beats delivered", DW'(e_data.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule